// File: doc/BRIEF.md
# Queued Conversion Command Sequencer

This block is the digital side of a multi-channel successive-approximation converter. It holds a 64-entry table of command words. Each word holds a 6-bit channel code and a stop-here (pause) bit. A 6-bit split point divides the table into one or two scan lists. Each list has its own trigger input. When a list is triggered, the sequencer walks it one entry at a time. For each entry it sends the channel code to the converter with a start pulse, waits for the done pulse, and stores the 10-bit value in the result table slot with the same index as the command.

Software fills the command table and reads both tables through a small register port. Sticky status pins report a pause reached, a list finished, and a trigger lost to overrun. A one-cycle clear vector lowers them. The converter side is a request/done handshake that carries its own back-pressure. The sequencer issues a start and then holds its next start until done returns, so at most one conversion is ever in flight. The converter may take as many cycles as it needs. A done pulse that arrives while nothing is outstanding is dropped.

Top module: `qconv_sequencer`

## Requirements
- R1: After reset no start pulse is issued, all status pins read 0, every command entry reads 7'h3F (end code, pause clear) and every result slot reads 0.
- R2: With reg_tbl=0, a reg_we pulse writes reg_wdata[6:0] into command entry reg_addr. Bit 6 is the pause bit and bits 5:0 are the channel code. reg_rdata returns the entry zero-extended. With reg_tbl=1, reg_rdata returns result slot reg_addr, and writes do nothing.
- R3: With q_boundary=0 there is one list, covering entries 0 to 63. A trigger converts the entries in ascending order, and each result lands in the slot whose index matches the command entry.
- R4: Channel code 63 ends a list without a conversion and sets that list's done flag. Reaching entry 63 or the last entry before the split also ends the list and sets the done flag.
- R5: An entry with the pause bit set is still converted. The list then stops and sets its pause flag, and the next trigger continues at the following entry.
- R6: A nonzero q_boundary B gives list 1 the entries 0..B-1 and list 2 the entries B..63.
- R7: When both lists are ready, list 1 takes the next conversion slot. List 2 then resumes at the entry where it stopped.
- R8: conv_start is high for one cycle and carries the entry's channel code on conv_chan unchanged, including codes 60, 61 and 62. No new start comes before conv_done, and a conv_done with no start outstanding changes no result slot.
- R9: A trigger to a list that is already running is ignored, and it sets that list's overrun flag.
- R10: Status flags stay set until cleared. stat_clr bits 1:0 clear the pause flags, bits 3:2 clear the done flags and bits 5:4 clear the overrun flags, with list 1 in the lower bit of each pair.
- R11: A trigger after a list has finished restarts that list at its first entry.
- R12: With q_boundary=0, a trigger on q_trig[1] has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| q_trig | input | 2 | Trigger pulse, bit 0 for list 1 and bit 1 for list 2 |
| q_boundary | input | 6 | First entry of list 2; 0 selects one list |
| reg_tbl | input | 1 | Register port table select: 0 for commands, 1 for results |
| reg_we | input | 1 | Command table write strobe |
| reg_addr | input | 6 | Register port entry index |
| reg_wdata | input | 7 | Command word to write (pause bit and channel) |
| reg_rdata | output | 10 | Read data for the selected table and entry |
| stat_clr | input | 6 | One-cycle clear for the status flags |
| stat_pause | output | 2 | Pause-reached flags |
| stat_done | output | 2 | List-finished flags |
| stat_ovr | output | 2 | Trigger-overrun flags |
| conv_start | output | 1 | Conversion start pulse |
| conv_chan | output | 6 | Channel code for the conversion |
| conv_done | input | 1 | Conversion finished pulse |
| conv_result | input | 10 | Conversion value, valid with conv_done |

## Verification
The bench checks the order of channels sent to a modelled converter against the command table, and checks that each value lands in the matching slot. A design with a pointer off by one would shift every stored value. The bench triggers list 2 first and list 1 while list 2 is mid-conversion. A design without list 1 priority, or one that restarts list 2 from its first entry, would produce a different channel order. A pause in the middle of the list is resumed to check that resumption does not restart the list, and a later trigger after the list finishes must restart it. Retriggering a running list, a stray done pulse with no start outstanding, and a list 2 trigger in single-list mode must each leave the conversion log and the stored results unchanged.

// File: rtl/qcs_pkg.sv
package qcs_pkg;
  localparam int CHAN_W  = 6;
  localparam int RES_W   = 10;
  localparam int IDX_W   = 6;
  localparam int ENTRIES = 1 << IDX_W;
  localparam int WORD_W  = CHAN_W + 1;
  localparam logic [CHAN_W-1:0] END_CODE = '1;
endpackage

// File: rtl/qcs_table.sv
module qcs_table #(
  parameter int AW  = 6,
  parameter int DW  = 7,
  parameter int NRD = 1,
  parameter logic [DW-1:0] RST = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [AW-1:0]            waddr,
  input  logic [DW-1:0]            wdata,
  input  logic [NRD-1:0][AW-1:0]   raddr,
  output logic [NRD-1:0][DW-1:0]   rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= RST;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata[g] = mem[raddr[g]];
  end
endmodule

// File: rtl/qcs_queue.sv
module qcs_queue #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [AW-1:0] first,
  input  logic          trig,
  input  logic          adv,
  input  logic          adv_pause,
  input  logic          adv_last,
  input  logic [2:0]    clr,      // {ovr, done, pause}
  output logic          run,
  output logic [AW-1:0] ptr,
  output logic          pau,
  output logic          cmp,
  output logic          ovr
);
  logic fresh;
  logic take;
  assign take = trig && en && !run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; ptr <= '0; fresh <= 1'b1;
      pau <= 1'b0; cmp <= 1'b0; ovr <= 1'b0;
    end else begin
      if (clr[0]) pau <= 1'b0;
      if (clr[1]) cmp <= 1'b0;
      if (clr[2]) ovr <= 1'b0;
      if (trig && en && run) ovr <= 1'b1;
      if (take) begin
        run   <= 1'b1;
        fresh <= 1'b0;
        if (fresh) ptr <= first;
      end else if (adv) begin
        if (adv_pause) pau <= 1'b1;
        if (adv_last) begin
          run <= 1'b0; cmp <= 1'b1; fresh <= 1'b1;
        end else begin
          ptr <= ptr + 1'b1;
          if (adv_pause) run <= 1'b0;
        end
      end
    end
  end

  // R5: the pointer moves only on a fresh start or an advance
  a_r5_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!(trig && en && !run) && !adv) |=> $stable(ptr));
  // R3: the engine advances only a running list
  a_r3_adv_running: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> run);
  // R9: overrun rises only from a trigger on a running list
  a_r9_ovr_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $past(run && trig));
endmodule

// File: rtl/qcs_engine.sv
module qcs_engine
  import qcs_pkg::*;
#(
  parameter int AW = IDX_W,
  parameter int CW = CHAN_W,
  parameter int RW = RES_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         run,
  input  logic [1:0][AW-1:0] ptr,
  input  logic [1:0][AW:0]   stop,
  output logic [AW-1:0]      cmd_raddr,
  input  logic [CW:0]        cmd_rdata,
  output logic               conv_start,
  output logic [CW-1:0]      conv_chan,
  input  logic               conv_done,
  input  logic [RW-1:0]      conv_result,
  output logic               res_we,
  output logic [AW-1:0]      res_waddr,
  output logic [RW-1:0]      res_wdata,
  output logic [1:0]         adv,
  output logic               adv_pause,
  output logic               adv_last
);
  logic          busy, cur_q, cur_pause, cur_last;
  logic [AW-1:0] cur_idx;
  logic          pick, any, is_end, last_sel;

  always_comb begin
    any       = |run;
    pick      = !run[0];
    cmd_raddr = ptr[pick];
    is_end    = (cmd_rdata[CW-1:0] == END_CODE);
    last_sel  = (({1'b0, cmd_raddr} + 1'b1) == stop[pick]);
    adv       = '0;
    adv_pause = 1'b0;
    adv_last  = 1'b0;
    res_we    = 1'b0;
    res_waddr = cur_idx;
    res_wdata = conv_result;
    if (!busy && any && is_end) begin
      adv[pick] = 1'b1;
      adv_last  = 1'b1;
    end else if (busy && conv_done) begin
      adv[cur_q] = 1'b1;
      adv_pause  = cur_pause;
      adv_last   = cur_last;
      res_we     = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; cur_q <= 1'b0; cur_pause <= 1'b0; cur_last <= 1'b0;
      cur_idx <= '0; conv_start <= 1'b0; conv_chan <= '0;
    end else begin
      conv_start <= 1'b0;
      if (!busy && any && !is_end) begin
        busy       <= 1'b1;
        cur_q      <= pick;
        cur_idx    <= cmd_raddr;
        cur_pause  <= cmd_rdata[CW];
        cur_last   <= last_sel;
        conv_start <= 1'b1;
        conv_chan  <= cmd_rdata[CW-1:0];
      end else if (busy && conv_done) begin
        busy <= 1'b0;
      end
    end
  end

  // R8: one conversion in flight, so starts never come back to back
  a_r8_one_inflight: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
  // R8: a result is stored only while a conversion is outstanding
  a_r8_store_busy: assert property (@(posedge clk) disable iff (!rst_n)
    res_we |-> busy);
  // R7: a ready list 1 wins the next slot when the engine is free
  a_r7_prio: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && run[0] && !is_end) |=> (conv_start && !cur_q));
endmodule

// File: rtl/qconv_sequencer.sv
module qconv_sequencer
  import qcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        q_trig,
  input  logic [IDX_W-1:0]  q_boundary,
  input  logic              reg_tbl,
  input  logic              reg_we,
  input  logic [IDX_W-1:0]  reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [RES_W-1:0]  reg_rdata,
  input  logic [5:0]        stat_clr,
  output logic [1:0]        stat_pause,
  output logic [1:0]        stat_done,
  output logic [1:0]        stat_ovr,
  output logic              conv_start,
  output logic [CHAN_W-1:0] conv_chan,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_result
);
  logic                     two_q;
  logic [1:0]               run, adv;
  logic [1:0][IDX_W-1:0]    ptr;
  logic [1:0][IDX_W:0]      stop;
  logic                     adv_pause, adv_last;
  logic [IDX_W-1:0]         cmd_raddr;
  logic [1:0][IDX_W-1:0]    cmd_ra;
  logic [1:0][WORD_W-1:0]   cmd_rd;
  logic                     res_we;
  logic [IDX_W-1:0]         res_waddr;
  logic [RES_W-1:0]         res_wdata;
  logic [0:0][IDX_W-1:0]    res_ra;
  logic [0:0][RES_W-1:0]    res_rd;

  assign two_q   = (q_boundary != '0);
  assign stop[0] = two_q ? {1'b0, q_boundary} : (IDX_W+1)'(ENTRIES);
  assign stop[1] = (IDX_W+1)'(ENTRIES);
  assign cmd_ra  = {reg_addr, cmd_raddr};
  assign res_ra  = reg_addr;
  assign reg_rdata = reg_tbl ? res_rd[0] : RES_W'(cmd_rd[1]);

  qcs_table #(.AW(IDX_W), .DW(WORD_W), .NRD(2), .RST({1'b0, END_CODE})) u_cmd (
    .clk(clk), .rst_n(rst_n), .we(reg_we && !reg_tbl), .waddr(reg_addr),
    .wdata(reg_wdata), .raddr(cmd_ra), .rdata(cmd_rd));

  qcs_table #(.AW(IDX_W), .DW(RES_W), .NRD(1), .RST('0)) u_res (
    .clk(clk), .rst_n(rst_n), .we(res_we), .waddr(res_waddr),
    .wdata(res_wdata), .raddr(res_ra), .rdata(res_rd));

  for (genvar g = 0; g < 2; g++) begin : g_q
    qcs_queue #(.AW(IDX_W)) u_q (
      .clk(clk), .rst_n(rst_n),
      .en(g == 0 ? 1'b1 : two_q),
      .first(g == 0 ? '0 : q_boundary),
      .trig(q_trig[g]), .adv(adv[g]), .adv_pause(adv_pause), .adv_last(adv_last),
      .clr({stat_clr[4+g], stat_clr[2+g], stat_clr[g]}),
      .run(run[g]), .ptr(ptr[g]),
      .pau(stat_pause[g]), .cmp(stat_done[g]), .ovr(stat_ovr[g]));
  end

  qcs_engine u_eng (
    .clk(clk), .rst_n(rst_n), .run(run), .ptr(ptr), .stop(stop),
    .cmd_raddr(cmd_raddr), .cmd_rdata(cmd_rd[0]),
    .conv_start(conv_start), .conv_chan(conv_chan),
    .conv_done(conv_done), .conv_result(conv_result),
    .res_we(res_we), .res_waddr(res_waddr), .res_wdata(res_wdata),
    .adv(adv), .adv_pause(adv_pause), .adv_last(adv_last));
endmodule

// File: tb/qconv_sequencer_bench.sv
module qconv_sequencer_bench;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [1:0] q_trig = 0;
  logic [5:0] q_boundary = 0;
  logic       reg_tbl = 0, reg_we = 0;
  logic [5:0] reg_addr = 0;
  logic [6:0] reg_wdata = 0;
  logic [9:0] reg_rdata;
  logic [5:0] stat_clr = 0;
  logic [1:0] stat_pause, stat_done, stat_ovr;
  logic       conv_start;
  logic [5:0] conv_chan;
  logic       conv_done;
  logic [9:0] conv_result;

  int tests = 0, fails = 0;
  bit finished = 0;
  bit model_en = 1;
  int log_n = 0;
  int issue_cnt = 0;
  logic [5:0] log_chan [64];
  logic [9:0] log_res  [64];

  always #5 clk = ~clk;

  qconv_sequencer u_qconv_sequencer (
    .clk(clk), .rst_n(rst_n), .q_trig(q_trig), .q_boundary(q_boundary),
    .reg_tbl(reg_tbl), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .stat_clr(stat_clr), .stat_pause(stat_pause),
    .stat_done(stat_done), .stat_ovr(stat_ovr), .conv_start(conv_start),
    .conv_chan(conv_chan), .conv_done(conv_done), .conv_result(conv_result));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // converter model: latency 3 cycles, value = {count, channel}
  initial begin
    conv_done = 0; conv_result = 0;
    forever begin
      @(negedge clk);
      if (model_en && conv_start) begin
        logic [9:0] r;
        r = {issue_cnt[3:0], conv_chan};
        issue_cnt++;
        log_chan[log_n] = conv_chan;
        log_res[log_n]  = r;
        log_n++;
        @(negedge clk);
        chk(conv_start == 0, "R8 start width", conv_start, 0);
        @(negedge clk);
        conv_done = 1; conv_result = r;
        @(negedge clk);
        conv_done = 0;
      end
    end
  end

  task automatic wcmd(input int a, input logic [6:0] w);
    @(negedge clk); reg_tbl = 0; reg_addr = 6'(a); reg_wdata = w; reg_we = 1;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input bit tbl, input int a, output logic [9:0] v);
    @(negedge clk); reg_tbl = tbl; reg_addr = 6'(a); #1 v = reg_rdata;
  endtask

  task automatic trig(input int q);
    @(negedge clk); q_trig[q] = 1; @(negedge clk); q_trig[q] = 0;
  endtask

  task automatic clr_all;
    @(negedge clk); stat_clr = 6'h3F; @(negedge clk); stat_clr = 0;
  endtask

  task automatic wait_done(input int q);
    for (int i = 0; i < 2000 && !stat_done[q] && !stat_pause[q]; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [9:0] v;
    chk(conv_start == 0, "R1 start", conv_start, 0);
    chk({stat_pause, stat_done, stat_ovr} == 0, "R1 status", {stat_pause, stat_done, stat_ovr}, 0);
    rd(0, 17, v); chk(v == 10'h03F, "R1 cmd reset", v, 10'h03F);
    rd(1, 40, v); chk(v == 0, "R1 result reset", v, 0);
  endtask

  task automatic t_regport;
    logic [9:0] v;
    wcmd(33, 7'h5A);
    rd(0, 33, v); chk(v == 10'h05A, "R2 cmd readback", v, 10'h05A);
    @(negedge clk); reg_tbl = 1; reg_addr = 33; reg_wdata = 7'h11; reg_we = 1;
    @(negedge clk); reg_we = 0;
    rd(1, 33, v); chk(v == 0, "R2 result not writable", v, 0);
    wcmd(33, 7'h3F);
  endtask

  task automatic t_single;
    logic [9:0] v;
    logic [5:0] ch [5] = '{3, 7, 60, 61, 62};
    q_boundary = 0;
    for (int i = 0; i < 5; i++) wcmd(i, {1'b0, ch[i]});
    clr_all(); log_n = 0;
    trig(0); wait_done(0);
    chk(log_n == 5, "R3 conversion count", log_n, 5);
    for (int i = 0; i < 5; i++) begin
      chk(log_chan[i] == ch[i], "R8 channel passed", log_chan[i], ch[i]);
      rd(1, i, v); chk(v == log_res[i], "R3 slot match", v, log_res[i]);
    end
    chk(stat_done == 2'b01 && stat_pause == 0, "R4 end code done", stat_done, 1);
  endtask

  task automatic t_sticky;
    repeat (20) @(negedge clk);
    chk(stat_done[0] == 1, "R10 sticky", stat_done[0], 1);
    @(negedge clk); stat_clr = 6'b000100; @(negedge clk); stat_clr = 0;
    chk(stat_done[0] == 0, "R10 clear", stat_done[0], 0);
  endtask

  task automatic t_pause;
    wcmd(1, 7'h47);   // pause bit on entry 1, channel 7
    clr_all(); log_n = 0;
    trig(0); wait_done(0);
    chk(log_n == 2, "R5 stop at pause", log_n, 2);
    chk(stat_pause[0] == 1 && stat_done[0] == 0, "R5 pause flag", {stat_pause[0], stat_done[0]}, 2);
    trig(0); wait_done(0); repeat (20) @(negedge clk);
    chk(log_n == 5, "R5 resume count", log_n, 5);
    chk(log_chan[2] == 60, "R5 resume entry", log_chan[2], 60);
    chk(stat_done[0] == 1, "R4 done after resume", stat_done[0], 1);
    clr_all(); log_n = 0;
    trig(0); wait_done(0);
    chk(log_n == 2 && log_chan[0] == 3, "R11 restart at first", log_chan[0], 3);
    trig(0); wait_done(0); repeat (20) @(negedge clk);
    wcmd(1, 7'h07);
  endtask

  task automatic t_overrun;
    clr_all(); log_n = 0;
    trig(0); repeat (2) @(negedge clk); trig(0);
    wait_done(0);
    chk(stat_ovr == 2'b01, "R9 overrun flag", stat_ovr, 1);
    chk(log_n == 5, "R9 trigger ignored", log_n, 5);
  endtask

  task automatic t_two;
    logic [9:0] v;
    q_boundary = 8;
    for (int i = 0; i < 8; i++) wcmd(i, 7'(i));
    wcmd(8, 7'd20); wcmd(9, 7'd21); wcmd(10, 7'd22); wcmd(11, 7'h3F);
    clr_all(); log_n = 0;
    trig(1);
    for (int i = 0; i < 50 && log_n == 0; i++) @(negedge clk);
    trig(0);
    for (int i = 0; i < 2000 && stat_done != 2'b11; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(log_n == 11, "R6 total count", log_n, 11);
    chk(log_chan[0] == 20, "R7 list 2 first", log_chan[0], 20);
    for (int i = 0; i < 8; i++) chk(log_chan[1+i] == 6'(i), "R7 list 1 priority", log_chan[1+i], i);
    chk(log_chan[9] == 21 && log_chan[10] == 22, "R7 list 2 resumes", log_chan[9], 21);
    rd(1, 8, v);  chk(v == log_res[0], "R6 list 2 slot", v, log_res[0]);
    rd(1, 7, v);  chk(v == log_res[8], "R6 list 1 last slot", v, log_res[8]);
    chk(stat_done == 2'b11, "R6 both done", stat_done, 3);
  endtask

  task automatic t_noq2;
    q_boundary = 0;
    clr_all(); log_n = 0;
    trig(1); repeat (30) @(negedge clk);
    chk(log_n == 0, "R12 no conversion", log_n, 0);
    chk({stat_done, stat_ovr} == 0, "R12 no status", {stat_done, stat_ovr}, 0);
  endtask

  task automatic t_stray;
    logic [9:0] a, b;
    rd(1, 0, a);
    model_en = 0;
    @(negedge clk); conv_done = 1; conv_result = 10'h3AA;
    @(negedge clk); conv_done = 0;
    rd(1, 0, b); chk(b == a, "R8 stray done slot 0", b, a);
    rd(1, 63, b); chk(b == 0, "R8 stray done slot 63", b, 0);
    model_en = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset(); t_regport(); t_single(); t_sticky(); t_pause();
    t_overrun(); t_two(); t_noq2(); t_stray();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule